// File: doc/BRIEF.md
# Configurable Parallel Bus Master Port

This block lets on-chip logic run single read and write cycles on an external 8-bit parallel bus, the kind used by character displays, byte-wide memories and other peripherals. The internal side presents one command at a time: a direction, an optional new address, write data and a set of configuration fields. Each completed transfer returns a one-cycle completion pulse, the captured read byte and the updated address counter.

One engine places the address in one of three ways. In the separate-lines scheme, every address bit has its own pin. In the half-shared scheme, the low address byte goes out on the data lines under a latch strobe and the upper bits stay on their own pins. In the fully shared scheme, both address bytes go out on the data lines, each under its own latch strobe. The control pins work either as a read strobe and a write strobe, or as a direction line plus an enable strobe. The chip select, the latch strobes and the transfer strobes each have a programmable active level. Three short counters stretch the cycle: setup before the strobe, the strobe width and the hold after it. After each transfer the address counter stays where it is, steps up or steps down, and wraps within the number of address bits that the selected scheme uses.

Top module: `par_bus_master`

## Requirements
- R1: A command is taken when cmdValid is high and busy is low. busy then stays high for exactly L + S + max(1,W) + H cycles. Here L is 0 (separate lines, cfgMuxMode=0), 1 (half-shared, cfgMuxMode=1) or 2 (fully shared, cfgMuxMode=2), and S, W, H are cfgSetup, cfgWidth and cfgHold. done is high for one cycle, in the first cycle that busy is low.
- R2: In the fully shared scheme, address bits 7:0 appear on busDataOut for one cycle with busLatchLo active. In the next cycle, address bits 15:8 appear with busLatchHi active. The two latch strobes are never active together.
- R3: In the half-shared scheme, address bits 7:0 appear on busDataOut for one cycle with busLatchLo active. Address bits 10:8 drive busAddr[10:8] during the transfer.
- R4: In the separate-lines scheme, address bits 10:0 drive busAddr[10:0]. When cfgCsAsAddr=1 and the scheme is not fully shared, busCs carries address bit 11 without polarity, and the address space grows from 11 to 12 bits.
- R5: With cfgStrobeStyle=0, only busRd pulses on reads and only busWr pulses on writes. With cfgStrobeStyle=1, busWr is the enable strobe and busRd is a direction line: 1 for read, 0 for write while busy, and 1 when idle.
- R6: Each pin group is driven at its active level when asserted and at the inverse when idle. The level is cfgPolCs for busCs (asserted for every busy cycle when it is not carrying an address bit), cfgPolLatch for both latch strobes, and cfgPolStrobe for the read, write and enable strobes.
- R7: busDataOe is high during the latch cycles and, for writes, from the first cycle after the address phase through the last hold cycle. It is low during reads after the address phase and whenever busy is low. During the strobe of a write, busDataOut carries the write byte.
- R8: On a read, rdData takes busDataIn as it stands in the last cycle of the active strobe and holds it at least through the done pulse.
- R9: The transfer address is cmdAddr when cmdLoad=1, otherwise the address counter. Either value is cut to the scheme's width: 16 bits when fully shared, 12 bits with cfgCsAsAddr, 11 bits otherwise. At done, curAddr equals that address unchanged (cfgStep 0 or 3), plus one (1) or minus one (2), wrapped to the same width.
- R10: After reset: busy=0, done=0, busDataOe=0, rdData=0, curAddr=0, and all strobes and the chip select are at their inactive levels.
- R11: A cmdValid that arrives while busy is high has no effect. The running transfer keeps its address, and no further transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdLoad | input | 1 | 1 = use cmdAddr, 0 = use the address counter |
| cmdAddr | input | 16 | Command address |
| cmdWdata | input | 8 | Write byte |
| cfgMuxMode | input | 2 | 0 separate lines, 1 half-shared, 2 fully shared |
| cfgCsAsAddr | input | 1 | Chip-select pin carries address bit 11 |
| cfgStrobeStyle | input | 1 | 0 read/write strobes, 1 direction plus enable |
| cfgStep | input | 2 | 0/3 hold, 1 increment, 2 decrement |
| cfgPolCs | input | 1 | Active level of chip select |
| cfgPolLatch | input | 1 | Active level of the latch strobes |
| cfgPolStrobe | input | 1 | Active level of the read/write/enable strobes |
| cfgSetup | input | 2 | Setup cycles before the strobe |
| cfgWidth | input | 2 | Strobe width in cycles (0 acts as 1) |
| cfgHold | input | 2 | Hold cycles after the strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Captured read byte |
| curAddr | output | 16 | Address counter |
| busAddr | output | 11 | Dedicated address lines |
| busCs | output | 1 | Chip select or address bit 11 |
| busLatchLo | output | 1 | Low address byte latch strobe |
| busLatchHi | output | 1 | High address byte latch strobe |
| busRd | output | 1 | Read strobe or direction line |
| busWr | output | 1 | Write strobe or enable strobe |
| busDataOut | output | 8 | Data lines, outgoing |
| busDataOe | output | 1 | Data line output enable |
| busDataIn | input | 8 | Data lines, incoming |

## Verification
The bench runs random mixes of scheme, strobe style, polarities and the three wait counts. It rebuilds the address seen on the pins from the latched bytes, the dedicated lines and the chip select, so that a swapped byte order or a bit 11 left off the chip-select pin shows up as a wrong address. It changes busDataIn on every strobe cycle, so a design that captures on the first strobe cycle, or in the cycle after the strobe, returns the wrong byte. Directed cases walk the counter across the wrap point of each address width, where a mask of the wrong width gives a wrong curAddr. Directed cases also run zero-width strobes, where a missing floor of one cycle shortens busy, and a command raised during a transfer, which a broken accept condition would take as a second transfer.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  localparam logic [1:0] MUX_PART = 2'd1;
  localparam logic [1:0] MUX_FULL = 2'd2;
  localparam logic [1:0] STEP_INC = 2'd1;
  localparam logic [1:0] STEP_DEC = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ALO   = 3'd1,
    ST_AHI   = 3'd2,
    ST_SETUP = 3'd3,
    ST_STRB  = 3'd4,
    ST_HOLD  = 3'd5
  } phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic start;      // command taken this cycle
    logic active;     // transfer in progress
    logic latchLo;    // low address byte phase
    logic latchHi;    // high address byte phase
    logic dataPhase;  // setup, strobe or hold
    logic strobe;     // transfer strobe active
    logic capture;    // last strobe cycle
    logic finish;     // last cycle of the transfer
  } busCtl_t;

endpackage

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import pbm_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cfgMuxMode,
  input  logic [WAIT_W-1:0] cfgSetup,
  input  logic [WAIT_W-1:0] cfgWidth,
  input  logic [WAIT_W-1:0] cfgHold,
  output busCtl_t           ctl,
  output logic              done
);

  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  phase_e            state, stateNxt;
  phase_e            dataEntry;
  logic [WAIT_W-1:0] cnt, cntNxt, dataEntryCnt, widthEff;
  logic              accept, cntZero, hasAddrPhase;

  assign widthEff     = (cfgWidth == '0) ? ONE : cfgWidth;
  assign accept       = cmdValid && (state == ST_IDLE);
  assign cntZero      = (cnt == '0);
  assign hasAddrPhase = (cfgMuxMode == MUX_FULL) || (cfgMuxMode == MUX_PART);

  // first state of the data phase: setup if any, else the strobe
  always_comb begin
    if (cfgSetup != '0) begin
      dataEntry    = ST_SETUP;
      dataEntryCnt = cfgSetup - ONE;
    end else begin
      dataEntry    = ST_STRB;
      dataEntryCnt = widthEff - ONE;
    end
  end

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          if (hasAddrPhase) begin
            stateNxt = ST_ALO;
          end else begin
            stateNxt = dataEntry;
            cntNxt   = dataEntryCnt;
          end
        end
      end
      ST_ALO: begin
        if (cfgMuxMode == MUX_FULL) begin
          stateNxt = ST_AHI;
        end else begin
          stateNxt = dataEntry;
          cntNxt   = dataEntryCnt;
        end
      end
      ST_AHI: begin
        stateNxt = dataEntry;
        cntNxt   = dataEntryCnt;
      end
      ST_SETUP: begin
        if (cntZero) begin
          stateNxt = ST_STRB;
          cntNxt   = widthEff - ONE;
        end else begin
          cntNxt = cnt - ONE;
        end
      end
      ST_STRB: begin
        if (!cntZero) begin
          cntNxt = cnt - ONE;
        end else if (cfgHold != '0) begin
          stateNxt = ST_HOLD;
          cntNxt   = cfgHold - ONE;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (cntZero) stateNxt = ST_IDLE;
        else         cntNxt   = cnt - ONE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.start     = accept;
    ctl.active    = (state != ST_IDLE);
    ctl.latchLo   = (state == ST_ALO);
    ctl.latchHi   = (state == ST_AHI);
    ctl.dataPhase = (state == ST_SETUP) || (state == ST_STRB) || (state == ST_HOLD);
    ctl.strobe    = (state == ST_STRB);
    ctl.capture   = (state == ST_STRB) && cntZero;
    ctl.finish    = ((state == ST_STRB) && cntZero && (cfgHold == '0)) ||
                    ((state == ST_HOLD) && cntZero);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      done  <= ctl.finish;
    end
  end

endmodule

// File: rtl/pbm_dpath.sv
module pbm_dpath
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic              cmdWrite,
  input  logic              cmdLoad,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [1:0]        cfgMuxMode,
  input  logic              cfgCsAsAddr,
  input  logic              cfgStrobeStyle,
  input  logic [1:0]        cfgStep,
  input  logic              cfgPolCs,
  input  logic              cfgPolLatch,
  input  logic              cfgPolStrobe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LINE_W-1:0] busAddr,
  output logic              busCs,
  output logic              busLatchLo,
  output logic              busLatchHi,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe
);

  localparam logic [ADDR_W-1:0] MASK_LINES = {ADDR_W{1'b1}} >> (ADDR_W - LINE_W);
  localparam logic [ADDR_W-1:0] MASK_CS    = {ADDR_W{1'b1}} >> (ADDR_W - LINE_W - 1);
  localparam logic [ADDR_W-1:0] ONE_A      = ADDR_W'(1);
  localparam int                HI_W       = LINE_W - DATA_W;

  logic [ADDR_W-1:0] xferAddr, addrCtr, addrMask, steppedAddr;
  logic [DATA_W-1:0] wdataReg, rdReg;
  logic              opWrite, csAddrEff, rdAct, wrAct;

  function automatic logic drivePol(input logic act, input logic pol);
    return act ? pol : ~pol;
  endfunction

  // width of the address space for the selected scheme
  always_comb begin
    if (cfgMuxMode == MUX_FULL) addrMask = '1;
    else if (cfgCsAsAddr)       addrMask = MASK_CS;
    else                        addrMask = MASK_LINES;
  end

  assign csAddrEff = cfgCsAsAddr && (cfgMuxMode != MUX_FULL);

  always_comb begin
    case (cfgStep)
      STEP_INC: steppedAddr = (xferAddr + ONE_A) & addrMask;
      STEP_DEC: steppedAddr = (xferAddr - ONE_A) & addrMask;
      default:  steppedAddr = xferAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferAddr <= '0;
      addrCtr  <= '0;
      wdataReg <= '0;
      rdReg    <= '0;
      opWrite  <= 1'b0;
    end else begin
      if (ctl.start) begin
        xferAddr <= (cmdLoad ? cmdAddr : addrCtr) & addrMask;
        wdataReg <= cmdWdata;
        opWrite  <= cmdWrite;
      end
      if (ctl.capture && !opWrite) rdReg <= busDataIn;
      if (ctl.finish) addrCtr <= steppedAddr;
    end
  end

  assign rdData  = rdReg;
  assign curAddr = addrCtr;

  // dedicated address lines per scheme
  generate
    if (HI_W > 0) begin : g_upperLines
      always_comb begin
        if (cfgMuxMode == MUX_FULL)      busAddr = '0;
        else if (cfgMuxMode == MUX_PART) busAddr = {xferAddr[LINE_W-1:DATA_W], {DATA_W{1'b0}}};
        else                             busAddr = xferAddr[LINE_W-1:0];
      end
    end else begin : g_noUpperLines
      always_comb begin
        if (cfgMuxMode == MUX_FULL || cfgMuxMode == MUX_PART) busAddr = '0;
        else                                                   busAddr = xferAddr[LINE_W-1:0];
      end
    end
  endgenerate

  assign busCs = csAddrEff ? xferAddr[LINE_W] : drivePol(ctl.active, cfgPolCs);

  assign busLatchLo = drivePol(ctl.latchLo, cfgPolLatch);
  assign busLatchHi = drivePol(ctl.latchHi, cfgPolLatch);

  always_comb begin
    if (ctl.latchLo)      busDataOut = xferAddr[DATA_W-1:0];
    else if (ctl.latchHi) busDataOut = DATA_W'(xferAddr >> DATA_W);
    else if (opWrite)     busDataOut = wdataReg;
    else                  busDataOut = '0;
  end

  assign busDataOe = ctl.latchLo || ctl.latchHi || (ctl.dataPhase && opWrite);

  assign rdAct = ctl.strobe && !opWrite;
  assign wrAct = ctl.strobe && opWrite;

  always_comb begin
    if (cfgStrobeStyle) begin
      busRd = ctl.active ? !opWrite : 1'b1;
      busWr = drivePol(ctl.strobe, cfgPolStrobe);
    end else begin
      busRd = drivePol(rdAct, cfgPolStrobe);
      busWr = drivePol(wrAct, cfgPolStrobe);
    end
  end

endmodule

// File: rtl/par_bus_master.sv
module par_bus_master
  import pbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LINE_W = 11,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic              cmdLoad,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [1:0]        cfgMuxMode,
  input  logic              cfgCsAsAddr,
  input  logic              cfgStrobeStyle,
  input  logic [1:0]        cfgStep,
  input  logic              cfgPolCs,
  input  logic              cfgPolLatch,
  input  logic              cfgPolStrobe,
  input  logic [WAIT_W-1:0] cfgSetup,
  input  logic [WAIT_W-1:0] cfgWidth,
  input  logic [WAIT_W-1:0] cfgHold,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [LINE_W-1:0] busAddr,
  output logic              busCs,
  output logic              busLatchLo,
  output logic              busLatchHi,
  output logic              busRd,
  output logic              busWr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn
);

  busCtl_t ctl;

  pbm_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cfgMuxMode(cfgMuxMode),
    .cfgSetup  (cfgSetup),
    .cfgWidth  (cfgWidth),
    .cfgHold   (cfgHold),
    .ctl       (ctl),
    .done      (done)
  );

  pbm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .cmdWrite      (cmdWrite),
    .cmdLoad       (cmdLoad),
    .cmdAddr       (cmdAddr),
    .cmdWdata      (cmdWdata),
    .cfgMuxMode    (cfgMuxMode),
    .cfgCsAsAddr   (cfgCsAsAddr),
    .cfgStrobeStyle(cfgStrobeStyle),
    .cfgStep       (cfgStep),
    .cfgPolCs      (cfgPolCs),
    .cfgPolLatch   (cfgPolLatch),
    .cfgPolStrobe  (cfgPolStrobe),
    .busDataIn     (busDataIn),
    .rdData        (rdData),
    .curAddr       (curAddr),
    .busAddr       (busAddr),
    .busCs         (busCs),
    .busLatchLo    (busLatchLo),
    .busLatchHi    (busLatchHi),
    .busRd         (busRd),
    .busWr         (busWr),
    .busDataOut    (busDataOut),
    .busDataOe     (busDataOe)
  );

  assign busy = ctl.active;

endmodule

// File: rtl/par_bus_master_chk.sv
module par_bus_master_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] curAddr,
  input logic              busDataOe,
  input logic              busLatchLo,
  input logic              busLatchHi,
  input logic              busRd,
  input logic              busWr,
  input logic              cfgPolLatch,
  input logic              cfgPolStrobe,
  input logic              cfgStrobeStyle
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R1

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R1

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !((busLatchLo == cfgPolLatch) && (busLatchHi == cfgPolLatch)));  // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !cfgStrobeStyle |-> !((busRd == cfgPolStrobe) && (busWr == cfgPolStrobe)));  // R5

  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (busWr != cfgPolStrobe));  // R6

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busDataOe);  // R7

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curAddr));  // R9

endmodule

bind par_bus_master par_bus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .busy          (busy),
  .done          (done),
  .curAddr       (curAddr),
  .busDataOe     (busDataOe),
  .busLatchLo    (busLatchLo),
  .busLatchHi    (busLatchHi),
  .busRd         (busRd),
  .busWr         (busWr),
  .cfgPolLatch   (cfgPolLatch),
  .cfgPolStrobe  (cfgPolStrobe),
  .cfgStrobeStyle(cfgStrobeStyle)
);

// File: tb/sim_par_bus_master.sv
module sim_par_bus_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0, cmdLoad = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic [7:0]  cmdWdata = '0;
  logic [1:0]  cfgMuxMode = '0, cfgStep = '0;
  logic        cfgCsAsAddr = 1'b0, cfgStrobeStyle = 1'b0;
  logic        cfgPolCs = 1'b0, cfgPolLatch = 1'b1, cfgPolStrobe = 1'b0;
  logic [1:0]  cfgSetup = '0, cfgWidth = '0, cfgHold = '0;
  logic        busy, done, busCs, busLatchLo, busLatchHi, busRd, busWr, busDataOe;
  logic [7:0]  rdData, busDataOut;
  logic [7:0]  busDataIn = '0;
  logic [15:0] curAddr;
  logic [10:0] busAddr;

  par_bus_master u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdLoad(cmdLoad),
    .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cfgMuxMode(cfgMuxMode), .cfgCsAsAddr(cfgCsAsAddr),
    .cfgStrobeStyle(cfgStrobeStyle), .cfgStep(cfgStep), .cfgPolCs(cfgPolCs),
    .cfgPolLatch(cfgPolLatch), .cfgPolStrobe(cfgPolStrobe), .cfgSetup(cfgSetup),
    .cfgWidth(cfgWidth), .cfgHold(cfgHold), .busy(busy), .done(done), .rdData(rdData),
    .curAddr(curAddr), .busAddr(busAddr), .busCs(busCs), .busLatchLo(busLatchLo),
    .busLatchHi(busLatchHi), .busRd(busRd), .busWr(busWr), .busDataOut(busDataOut),
    .busDataOe(busDataOe), .busDataIn(busDataIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [15:0] expCtr = '0;

  // transfer expectations shared with the bus monitor
  bit          expWriteG = 0, csAddrEffG = 0;
  logic [7:0]  expWdataG = '0, fvalG = '0;

  // bus monitor results
  bit          prevBusy = 0;
  int          busyCnt, stbCnt, oeErr, wrongStb, dirErr, csErr, wrErr;
  logic [7:0]  loByte, hiByte;
  logic [10:0] linesSeen;
  logic        csSeen;

  always @(negedge clk) begin
    if (busy && !prevBusy) begin
      busyCnt = 0; stbCnt = 0; oeErr = 0; wrongStb = 0; dirErr = 0; csErr = 0; wrErr = 0;
      loByte = '0; hiByte = '0; linesSeen = '0; csSeen = 1'b0;
    end
    if (busy) begin
      logic latchAct, stbAct;
      busyCnt++;
      latchAct = (busLatchLo == cfgPolLatch) || (busLatchHi == cfgPolLatch);
      if (busLatchLo == cfgPolLatch) loByte = busDataOut;
      if (busLatchHi == cfgPolLatch) hiByte = busDataOut;
      if (latchAct) begin
        if (!busDataOe) oeErr++;
      end else if (busDataOe != expWriteG) oeErr++;
      if (cfgStrobeStyle) begin
        stbAct = (busWr == cfgPolStrobe);
        if (busRd != !expWriteG) dirErr++;
      end else begin
        stbAct = expWriteG ? (busWr == cfgPolStrobe) : (busRd == cfgPolStrobe);
        if (expWriteG ? (busRd == cfgPolStrobe) : (busWr == cfgPolStrobe)) wrongStb++;
      end
      if (!csAddrEffG && busCs != cfgPolCs) csErr++;
      if (stbAct) begin
        stbCnt++;
        linesSeen = busAddr;
        csSeen = busCs;
        if (expWriteG && busDataOut != expWdataG) wrErr++;
        if (!expWriteG) busDataIn = fvalG ^ 8'(stbCnt);
      end
    end
    prevBusy = busy;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] maskFor(input logic [1:0] mode, input logic csA);
    if (mode == 2'd2) return 16'hFFFF;
    return csA ? 16'h0FFF : 16'h07FF;
  endfunction

  function automatic logic [15:0] stepFor(input logic [15:0] a, input logic [1:0] st, input logic [15:0] m);
    if (st == 2'd1) return (a + 16'd1) & m;
    if (st == 2'd2) return (a - 16'd1) & m;
    return a;
  endfunction

  function automatic logic [7:0] fOf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic setCfg(input logic [1:0] mode, input logic csA, input logic style, input logic [1:0] st,
                        input logic pc, input logic pl, input logic ps,
                        input logic [1:0] s, input logic [1:0] w, input logic [1:0] h);
    cfgMuxMode = mode; cfgCsAsAddr = csA; cfgStrobeStyle = style; cfgStep = st;
    cfgPolCs = pc; cfgPolLatch = pl; cfgPolStrobe = ps;
    cfgSetup = s; cfgWidth = w; cfgHold = h;
  endtask

  task automatic doTxn(input bit wr, input bit ld, input logic [15:0] a, input logic [7:0] wd, input bit poke);
    logic [15:0] m, used, seen;
    int nExp, wEff, k;
    bit gotDone;
    m = maskFor(cfgMuxMode, cfgCsAsAddr);
    used = (ld ? a : expCtr) & m;
    wEff = (cfgWidth == 0) ? 1 : int'(cfgWidth);
    nExp = ((cfgMuxMode == 2'd2) ? 2 : (cfgMuxMode == 2'd1) ? 1 : 0)
           + int'(cfgSetup) + wEff + int'(cfgHold);
    expWriteG = wr; expWdataG = wd; fvalG = fOf(used);
    csAddrEffG = cfgCsAsAddr && (cfgMuxMode != 2'd2);
    cmdValid = 1'b1; cmdWrite = wr; cmdLoad = ld; cmdAddr = a; cmdWdata = wd;
    gotDone = 0;
    for (k = 1; k <= 40; k++) begin
      @(negedge clk); #1;
      if (k == 1) begin
        if (poke) begin
          // R11: a second request raised while busy
          cmdWrite = !wr; cmdLoad = 1'b1; cmdAddr = ~a; cmdWdata = ~wd;
        end else cmdValid = 1'b0;
      end else if (k == 2) cmdValid = 1'b0;
      if (done) begin gotDone = 1; break; end
    end
    check(gotDone, "R1 done seen", 32'(gotDone), 1);
    check(!busy, "R1 idle at done", 32'(busy), 0);
    check(busyCnt == nExp, "R1 busy length", busyCnt, nExp);
    check(stbCnt == wEff, "R6 strobe width", stbCnt, wEff);
    if (cfgMuxMode == 2'd2) begin
      seen = {hiByte, loByte};
      check(seen == used, "R2 address bytes", seen, used);
    end else if (cfgMuxMode == 2'd1) begin
      seen = {4'b0, csAddrEffG ? csSeen : 1'b0, linesSeen[10:8], loByte};
      check(seen == used, "R3 address lines", seen, used);
    end else begin
      seen = {4'b0, csAddrEffG ? csSeen : 1'b0, linesSeen};
      check(seen == used, "R4 address lines", seen, used);
    end
    check(oeErr == 0, "R7 output enable", oeErr, 0);
    check(wrongStb == 0 && dirErr == 0, "R5 strobe style", wrongStb + dirErr, 0);
    check(csErr == 0, "R6 chip select", csErr, 0);
    if (wr) check(wrErr == 0, "R7 write data", wrErr, 0);
    else    check(rdData == (fOf(used) ^ 8'(wEff)), "R8 read capture", rdData, fOf(used) ^ 8'(wEff));
    expCtr = stepFor(used, cfgStep, m);
    check(curAddr == expCtr, "R9 address counter", curAddr, expCtr);
    check(busLatchLo == !cfgPolLatch && busLatchHi == !cfgPolLatch, "R6 latch idle",
          {busLatchLo, busLatchHi}, {!cfgPolLatch, !cfgPolLatch});
    if (cfgStrobeStyle)
      check(busWr == !cfgPolStrobe && busRd == 1'b1, "R5 idle direction", {busRd, busWr}, {1'b1, !cfgPolStrobe});
    else
      check(busWr == !cfgPolStrobe && busRd == !cfgPolStrobe, "R6 strobe idle",
            {busRd, busWr}, {!cfgPolStrobe, !cfgPolStrobe});
    if (!csAddrEffG) check(busCs == !cfgPolCs, "R6 cs idle", busCs, !cfgPolCs);
    @(negedge clk); #1;
    check(!done, "R1 done one cycle", 32'(done), 0);
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        check(!busy, "R11 no extra transfer", 32'(busy), 0);
        @(negedge clk); #1;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !busDataOe, "R10 reset flags", {busy, done, busDataOe}, 0);
    check(rdData == 0 && curAddr == 0, "R10 reset data", {rdData, curAddr}, 0);
    check(busRd == 1'b1 && busWr == 1'b1 && busLatchLo == 1'b0 && busCs == 1'b1, "R10 reset pins",
          {busRd, busWr, busLatchLo, busCs}, 4'b1101);
    rstN = 1'b1;
    @(negedge clk); #1;

    // R2 fully shared, counter wraps from 0xFFFF up to 0
    setCfg(2'd2, 0, 0, 2'd1, 0, 1, 0, 2'd1, 2'd2, 2'd1);
    doTxn(1, 1, 16'hFFFF, 8'hA5, 0);
    check(curAddr == 16'h0000, "R9 16-bit wrap", curAddr, 0);
    doTxn(0, 0, 16'h0, 8'h0, 0);
    // R4 separate lines, decrement wraps to 0x7FF
    setCfg(2'd0, 0, 1, 2'd2, 1, 0, 1, 2'd0, 2'd0, 2'd0);
    doTxn(0, 1, 16'hF800, 8'h00, 0);
    check(curAddr == 16'h07FF, "R9 11-bit wrap", curAddr, 16'h07FF);
    // R4 chip select as bit 11, decrement wraps to 0xFFF
    setCfg(2'd0, 1, 0, 2'd2, 0, 1, 1, 2'd3, 2'd3, 2'd3);
    doTxn(1, 1, 16'h0000, 8'h3C, 0);
    check(curAddr == 16'h0FFF, "R9 12-bit wrap", curAddr, 16'h0FFF);
    doTxn(0, 0, 16'h0, 8'h0, 0);
    // R3 half-shared, increment wraps to 0
    setCfg(2'd1, 0, 1, 2'd1, 1, 1, 0, 2'd0, 2'd3, 2'd0);
    doTxn(0, 1, 16'h07FF, 8'h00, 0);
    check(curAddr == 16'h0000, "R9 half-shared wrap", curAddr, 0);
    // R9 fixed address stays put
    setCfg(2'd1, 1, 0, 2'd0, 0, 0, 0, 2'd1, 2'd1, 2'd1);
    doTxn(1, 1, 16'h0ABC, 8'h11, 0);
    check(curAddr == 16'h0ABC, "R9 fixed address", curAddr, 16'h0ABC);
    // R11 request while busy, shortest and longer cycles
    setCfg(2'd0, 0, 0, 2'd1, 0, 1, 0, 2'd0, 2'd0, 2'd0);
    doTxn(1, 1, 16'h0123, 8'h77, 1);
    setCfg(2'd2, 0, 1, 2'd1, 1, 0, 1, 2'd2, 2'd1, 2'd2);
    doTxn(0, 1, 16'h8421, 8'h00, 1);

    for (int i = 0; i < 300; i++) begin
      setCfg(2'($urandom_range(0, 2)), 1'($urandom), 1'($urandom), 2'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom),
             2'($urandom), 2'($urandom), 2'($urandom));
      doTxn(1'($urandom), ($urandom_range(0, 2) == 0), 16'($urandom), 8'($urandom), ($urandom_range(0, 9) == 0));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule